// File: doc/BRIEF.md
# Clock-Correction Elastic Buffer

This block sits on one receive lane of a serial link. Words arrive on the clock recovered from the line. They leave on the local clock, which comes from a different oscillator, so the two rates differ by a small amount. A dual-clock FIFO absorbs the phase difference between the two clocks. The rate difference is absorbed by editing the stream, and only at words that the upstream logic marks as clock-correction words.

When the write side sees the buffer running fuller than its upper threshold, it discards an arriving correction word. When the read side sees the buffer running emptier than its lower threshold, it presents the correction word at the head a second time. Data words are never touched. If correction words arrive too rarely to keep up with the drift, the buffer eventually fills or empties, and a sticky error flag reports this.

After reset, both pointers are zero and output is held off until the buffer reaches half full. This places the read point at the centre of the storage.

Top module: `elastic_buffer`

## Requirements
- R1: While reset is asserted, rd_valid, ovf and unf are all 0.
- R2: After reset, rd_valid stays 0 until at least DEPTH/2 words have been written.
- R3: Every word written with wr_is_cc=0 appears exactly once on rd_data with rd_is_cc=0, in write order, as long as neither error flag is set.
- R4: When the write clock is faster than the read clock and correction words arrive often enough, some correction words are discarded (fewer leave than enter) and ovf stays 0.
- R5: When the read clock is faster and correction words arrive often enough, some correction words are presented twice (more leave than enter) and unf stays 0.
- R6: Every output with rd_is_cc=1 carries the data of a written correction word. Only words written with wr_is_cc=1 are ever discarded or repeated.
- R7: If the write clock is faster and no correction words arrive, ovf rises and then stays 1 until reset.
- R8: If the read clock is faster and no correction words arrive, unf rises and stays 1 until reset. rd_valid is 0 whenever unf is 1.
- R9: A reset after an error clears both flags and restarts output through the half-full wait of R2.
- R10: If correction words are written singly (never two in a row), the output never shows more than two consecutive correction words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| rd_clk | input | 1 | Local (read) clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | A word is present on wr_data this write cycle |
| wr_is_cc | input | 1 | The present word is a clock-correction word |
| wr_data | input | W | Incoming word |
| rd_valid | output | 1 | rd_data holds a word this read cycle |
| rd_is_cc | output | 1 | The output word is a clock-correction word |
| rd_data | output | W | Outgoing word |
| ovf | output | 1 | Sticky overflow: a word was lost because the buffer was full |
| unf | output | 1 | Sticky underflow: the buffer ran empty while streaming |

## Verification
The assertions assume that reset is applied to both clock domains together. They also assume that wr_is_cc is raised only on words that really are correction characters, because the repeat and discard checks trust that marking. The stimulus keeps to this: it drives one fixed value on every marked word, drives a running count on all others, and never places two marked words back to back. Clock ratios are held at about five percent so that each scenario reaches its intended steady state or error well within the run.

// File: rtl/eb_pkg.sv
`timescale 1ns/1ps
package eb_pkg;
  localparam int EB_PW = 16;
  typedef logic [EB_PW-1:0] eb_ptr_t;

  function automatic eb_ptr_t eb_bin2gray(eb_ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic eb_ptr_t eb_gray2bin(eb_ptr_t g);
    eb_ptr_t b;
    b[EB_PW-1] = g[EB_PW-1];
    for (int i = EB_PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // occupancy = (ahead - behind) modulo 2^pw
  function automatic eb_ptr_t eb_fill(eb_ptr_t ahead, eb_ptr_t behind, int unsigned pw);
    eb_ptr_t m;
    m = (eb_ptr_t'(1) << pw) - eb_ptr_t'(1);
    return (ahead - behind) & m;
  endfunction
endpackage

// File: rtl/eb_sync.sv
`timescale 1ns/1ps
module eb_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eb_wr_ctrl.sv
`timescale 1ns/1ps
module eb_wr_ctrl
  import eb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int HI    = 20
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic                       wr_en,
  input  logic                       wr_is_cc,
  input  logic [$clog2(DEPTH):0]     rgray_s,
  output logic                       push,
  output logic [$clog2(DEPTH)-1:0]   waddr,
  output logic [$clog2(DEPTH):0]     wgray,
  output logic                       ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_P = PW'(DEPTH);
  localparam logic [PW-1:0] HI_P   = PW'(HI);

  logic [PW-1:0] wbin, rbin_s, wfill;
  logic          cc_drop, full_hit;

  assign rbin_s   = PW'(eb_gray2bin(eb_ptr_t'(rgray_s)));
  assign wfill    = PW'(eb_fill(eb_ptr_t'(wbin), eb_ptr_t'(rbin_s), PW));
  assign cc_drop  = wr_en && wr_is_cc && (wfill > HI_P);
  assign full_hit = wr_en && !cc_drop && (wfill == FULL_P);
  assign push     = wr_en && !cc_drop && !full_hit;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) begin
        wbin  <= wbin + 1'b1;
        wgray <= PW'(eb_bin2gray(eb_ptr_t'(wbin + 1'b1)));
      end
      if (full_hit) ovf <= 1'b1;
    end
  end

  assert_wfill_bounded_R7: assert property (@(posedge clk) disable iff (!arst_n)
    wfill <= FULL_P) else $error("write-side fill beyond depth");
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!arst_n)
    ovf |=> ovf) else $error("overflow flag cleared without reset");
  assert_drop_below_full_R6: assert property (@(posedge clk) disable iff (!arst_n)
    cc_drop |=> $stable(wbin)) else $error("pointer moved on a discarded word");
endmodule

// File: rtl/eb_rd_ctrl.sv
`timescale 1ns/1ps
module eb_rd_ctrl
  import eb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  parameter int LO    = 12
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic [$clog2(DEPTH):0]     wgray_s,
  input  logic [W:0]                 head_word,
  output logic [$clog2(DEPTH)-1:0]   raddr,
  output logic [$clog2(DEPTH):0]     rgray,
  output logic                       rd_repeat,
  output logic                       rd_valid,
  output logic                       rd_is_cc,
  output logic [W-1:0]               rd_data,
  output logic                       unf
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LO_P   = PW'(LO);

  logic [PW-1:0] rbin, wbin_s, rfill;
  logic          started, rep_done, avail, unf_hit, advance;

  assign wbin_s    = PW'(eb_gray2bin(eb_ptr_t'(wgray_s)));
  assign rfill     = PW'(eb_fill(eb_ptr_t'(wbin_s), eb_ptr_t'(rbin), PW));
  assign avail     = started && !unf && (rfill != '0);
  assign unf_hit   = started && !unf && (rfill == '0);
  assign rd_repeat = avail && head_word[W] && !rep_done && (rfill < LO_P);
  assign advance   = avail && !rd_repeat;
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      started  <= 1'b0;
      rep_done <= 1'b0;
      unf      <= 1'b0;
      rd_valid <= 1'b0;
      rd_is_cc <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (!started && rfill >= HALF_P) started <= 1'b1;
      if (unf_hit) unf <= 1'b1;
      if (advance) begin
        rbin  <= rbin + 1'b1;
        rgray <= PW'(eb_bin2gray(eb_ptr_t'(rbin + 1'b1)));
      end
      if (rd_repeat)    rep_done <= 1'b1;
      else if (advance) rep_done <= 1'b0;
      rd_valid <= avail;
      rd_is_cc <= avail && head_word[W];
      if (avail) rd_data <= head_word[W-1:0];
    end
  end

  assert_rfill_bounded_R8: assert property (@(posedge clk) disable iff (!arst_n)
    rfill <= FULL_P) else $error("read-side fill beyond depth");
  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!arst_n)
    unf |=> unf) else $error("underflow flag cleared without reset");
  assert_quiet_after_unf_R8: assert property (@(posedge clk) disable iff (!arst_n)
    unf |-> !rd_valid) else $error("output valid while underflowed");
  assert_repeat_is_cc_R6: assert property (@(posedge clk) disable iff (!arst_n)
    rd_repeat |=> rd_valid && rd_is_cc) else $error("repeated word is not a correction word");
  assert_no_output_before_start_R2: assert property (@(posedge clk) disable iff (!arst_n)
    !started |=> !rd_valid) else $error("output before half-full start");
endmodule

// File: rtl/elastic_buffer.sv
`timescale 1ns/1ps
module elastic_buffer #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         arst_n,
  input  logic         wr_en,
  input  logic         wr_is_cc,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  output logic         rd_is_cc,
  output logic [W-1:0] rd_data,
  output logic         ovf,
  output logic         unf
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int BAND = DEPTH / 8;
  localparam int HI   = DEPTH / 2 + BAND;
  localparam int LO   = DEPTH / 2 - BAND;

  logic [W:0]    mem [DEPTH];
  logic          push, rd_repeat;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [W:0]    head_word;

  always_ff @(posedge wr_clk) begin
    if (push) mem[waddr] <= {wr_is_cc, wr_data};
  end
  assign head_word = mem[raddr];

  eb_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .arst_n(arst_n), .d(rgray), .q(rgray_s));
  eb_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .arst_n(arst_n), .d(wgray), .q(wgray_s));

  eb_wr_ctrl #(.DEPTH(DEPTH), .HI(HI)) u_wr (
    .clk(wr_clk), .arst_n(arst_n), .wr_en(wr_en), .wr_is_cc(wr_is_cc),
    .rgray_s(rgray_s), .push(push), .waddr(waddr), .wgray(wgray), .ovf(ovf));

  eb_rd_ctrl #(.DEPTH(DEPTH), .W(W), .LO(LO)) u_rd (
    .clk(rd_clk), .arst_n(arst_n), .wgray_s(wgray_s), .head_word(head_word),
    .raddr(raddr), .rgray(rgray), .rd_repeat(rd_repeat), .rd_valid(rd_valid),
    .rd_is_cc(rd_is_cc), .rd_data(rd_data), .unf(unf));

  assert_stored_cc_on_repeat_R6: assert property (@(posedge rd_clk) disable iff (!arst_n)
    rd_repeat |-> head_word[W]) else $error("repeat chosen on a data word");
endmodule

// File: tb/elastic_buffer_tb_top.sv
`timescale 1ns/1ps
module elastic_buffer_tb_top;
  localparam int W     = 16;
  localparam int DEPTH = 32;
  localparam int HALF  = DEPTH / 2;
  localparam logic [W-1:0] CCW = 16'hBC50;

  logic wclk = 1'b0, rclk = 1'b0, arst_n = 1'b0;
  logic wr_en = 1'b0, wr_is_cc = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic rd_valid, rd_is_cc, ovf, unf;
  logic [W-1:0] rd_data;
  real  rhalf = 4.0;

  int checks = 0, errors = 0;
  int words_in = 0, cc_in = 0, cc_out = 0, cons_cc = 0;
  bit seen_valid = 0, check_order = 0, done = 0;
  logic [W-1:0] dcount = '0;
  logic [W-1:0] expq[$];

  always #4 wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  elastic_buffer #(.W(W), .DEPTH(DEPTH)) dut_i (
    .wr_clk(wclk), .rd_clk(rclk), .arst_n(arst_n), .wr_en(wr_en),
    .wr_is_cc(wr_is_cc), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_is_cc(rd_is_cc), .rd_data(rd_data), .ovf(ovf), .unf(unf));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference: stream of data words in order; correction words counted only
  always @(negedge rclk) begin
    if (!arst_n) begin
      cons_cc    = 0;
      seen_valid = 0;
    end else if (rd_valid) begin
      if (!seen_valid) begin
        seen_valid = 1;
        check(words_in >= HALF, "R2", words_in, HALF);
      end
      if (rd_is_cc) begin
        cc_out++;
        cons_cc++;
        check(rd_data == CCW, "R6", rd_data, CCW);
        check(cons_cc <= 2, "R10", cons_cc, 2);
      end else begin
        cons_cc = 0;
        if (check_order) begin
          if (expq.size() == 0) check(0, "R3", rd_data, 0);
          else begin
            logic [W-1:0] e;
            e = expq.pop_front();
            check(rd_data == e, "R3", rd_data, e);
          end
        end
      end
    end
  end

  task automatic do_reset(input real rh, input string req);
    @(negedge wclk);
    arst_n = 0;
    wr_en  = 0;
    rhalf  = rh;
    repeat (4) @(negedge wclk);
    check(!rd_valid && !ovf && !unf, req, {rd_valid, ovf, unf}, 0);
    expq.delete();
    words_in = 0; cc_in = 0; cc_out = 0;
    arst_n = 1;
  endtask

  task automatic send(input int n, input int cc_every);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1;
      if (cc_every != 0 && (i % cc_every) == cc_every - 1) begin
        wr_is_cc = 1; wr_data = CCW; cc_in++;
      end else begin
        wr_is_cc = 0; wr_data = dcount; expq.push_back(dcount); dcount++;
      end
      words_in++;
    end
    @(negedge wclk);
    wr_en = 0; wr_is_cc = 0;
  endtask

  initial begin
    // matched clocks
    check_order = 1;
    do_reset(4.0, "R1");
    send(2000, 8);
    check(!ovf && !unf, "R3", {ovf, unf}, 0);
    // write side faster
    do_reset(4.2, "R1");
    send(3000, 8);
    check(cc_out < cc_in, "R4", cc_out, cc_in);
    check(!ovf, "R4", ovf, 0);
    // read side faster
    do_reset(3.8, "R1");
    send(3000, 8);
    check(cc_out > cc_in, "R5", cc_out, cc_in);
    check(!unf, "R5", unf, 0);
    // write faster, no correction words
    check_order = 0;
    do_reset(4.2, "R1");
    send(2000, 0);
    check(ovf == 1, "R7", ovf, 1);
    repeat (100) @(negedge wclk);
    check(ovf == 1, "R7", ovf, 1);
    // read faster, no correction words
    do_reset(3.8, "R9");
    send(2000, 0);
    repeat (10) @(negedge rclk);
    check(unf == 1, "R8", unf, 1);
    repeat (100) @(negedge rclk);
    check(unf == 1 && !rd_valid, "R8", {unf, rd_valid}, 2'b10);
    // recovery after errors
    check_order = 1;
    do_reset(4.0, "R9");
    send(1000, 6);
    check(!ovf && !unf && seen_valid, "R9", {ovf, unf, seen_valid}, 3'b001);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule